// File: doc/BRIEF.md
# Timed Serial Bus Frame Serializer

This block sends one serial frame per start strobe. Each data bit of the frame is taken from one of two 32-bit parallel words. A per-bit select mask makes the choice, unless a bypass control forces every bit to come from the primary word. The number of data bits can be programmed. A zero marker bit can be placed ahead of the data, at a programmable point in the middle, or in both places.

An 8-bit chip-select vector follows the frame. One programmable pattern drives it during the first part of the frame. A second pattern takes over from the middle split point to the end. The bit rate comes from a clock-enable input. Every bit lasts two enable ticks, and SCK is high during the second tick.

All configuration and data inputs are captured on the cycle the start strobe is accepted. Changing them during a frame has no effect on that frame.

Top module: `tsb_serializer`

## Requirements
- R1: After reset, and whenever no frame is in progress, `sdo`, `sck`, every `cs_out` line, `busy` and `done` are all 0.
- R2: The frame carries `max(cfg_count,3)+1` data bits. A count of 0, 1 or 2 behaves as 3. The total number of SCK pulses is that value, plus 1 if `ins_head` is set, plus 1 if `ins_mid` is set.
- R3: Data bits go out with the highest index first. With N data bits, the first data bit is bit N-1 and the last is bit 0.
- R4: When `bypass` is 0, data bit i equals `alt_word[i]` if `sel_mask[i]` is 1, and `prim_word[i]` if it is 0.
- R5: When `bypass` is 1, every data bit i equals `prim_word[i]`, whatever the mask holds.
- R6: When `ins_head` is 1, a single 0 bit is sent before the first data bit.
- R7: Let the split point be `M = min(mid_pos, N)`. When `ins_mid` is 1, a single 0 bit is sent after exactly M data bits.
- R8: `cs_out` is high where asserted. It equals `cs_first` before the split point and `cs_second` from the split point on. The split point is reached when M data bits have been sent. The middle zero bit and the head zero bit are counted as shown: the middle zero bit belongs to the second part, and the head zero bit belongs to the first part.
- R9: A start strobe is accepted in any cycle with `busy` low. Each bit is held for two `bit_tick` ticks: SCK is 0 during the first tick and 1 during the second. `sdo` changes only when SCK falls.
- R10: `busy` rises the cycle after the accepted strobe. It falls after the second tick of the last bit. In that same cycle `done` is high for exactly one clock, and the chip selects return to 0.
- R11: A start strobe that arrives while `busy` is high is ignored. The frame in progress continues unchanged.
- R12: Input words, mask, chip-select patterns and configuration are captured when the strobe is accepted. Later changes do not affect the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | Clock enable, two ticks per bit |
| start | input | 1 | Frame start strobe |
| cfg_count | input | 5 | Data bit count minus one |
| mid_pos | input | 5 | Data bits sent before the split point |
| ins_head | input | 1 | Insert zero bit ahead of data |
| ins_mid | input | 1 | Insert zero bit at split point |
| bypass | input | 1 | Ignore mask, use primary word |
| prim_word | input | 32 | Primary data word |
| alt_word | input | 32 | Alternate data word |
| sel_mask | input | 32 | Per-bit source select, 1 = alternate |
| cs_first | input | 8 | Chip-select pattern before split |
| cs_second | input | 8 | Chip-select pattern from split on |
| sdo | output | 1 | Serial data out |
| sck | output | 1 | Serial clock |
| cs_out | output | 8 | Chip selects, 1 = asserted |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The hardest cases are the corner positions of the split point. These include a split at zero with a head zero bit present, and a split clamped to the end of the data. In the clamped case the middle zero bit becomes the last bit of the frame. The stimulus reaches these by programming small counts, including clamped ones, together with large and zero `mid_pos` values. It also drives a frame with a slow tick divider, then changes every input word and pulses start again in the middle of that frame. A behavioural model holds the frame bits captured at acceptance, so any leak of live inputs into the frame is caught.

// File: rtl/tsb_pkg.sv
package tsb_pkg;

    localparam int TSB_DATA_W = 32;
    localparam int TSB_CS_W   = 8;
    localparam int TSB_CNT_W  = $clog2(TSB_DATA_W);
    localparam int TSB_POS_W  = $clog2(TSB_DATA_W + 2) + 1;

    typedef logic [TSB_POS_W-1:0] tsb_pos_t;

    typedef struct packed {
        logic [TSB_CNT_W-1:0]  count;
        logic [TSB_CNT_W-1:0]  mid;
        logic                  head_en;
        logic                  mid_en;
        logic                  bypass;
        logic [TSB_DATA_W-1:0] prim;
        logic [TSB_DATA_W-1:0] alt;
        logic [TSB_DATA_W-1:0] mask;
        logic [TSB_CS_W-1:0]   cs_a;
        logic [TSB_CS_W-1:0]   cs_b;
    } tsb_cfg_t;

    typedef struct packed {
        logic                busy;
        logic                phase;
        tsb_pos_t            pos;
    } tsb_seq_t;

    function automatic tsb_pos_t tsb_data_len(input logic [TSB_CNT_W-1:0] cnt,
                                              input int unsigned min_cnt);
        tsb_pos_t c;
        c = tsb_pos_t'(cnt);
        if (c < tsb_pos_t'(min_cnt))
            c = tsb_pos_t'(min_cnt);
        return c + tsb_pos_t'(1);
    endfunction

    function automatic logic tsb_pick(input logic byp, input logic sel,
                                      input logic p, input logic a);
        return (byp || !sel) ? p : a;
    endfunction

endpackage

// File: rtl/tsb_cfg_latch.sv
module tsb_cfg_latch
    import tsb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  tsb_cfg_t cfg_in,
    output tsb_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (load)
            cfg_q <= cfg_in;
    end

endmodule

// File: rtl/tsb_frame_seq.sv
module tsb_frame_seq
    import tsb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     accept,
    input  logic     tick,
    input  tsb_pos_t last_pos,
    output tsb_seq_t seq,
    output logic     done
);

    tsb_seq_t nxt;
    logic     end_now;

    always_comb begin
        nxt     = seq;
        end_now = 1'b0;
        if (accept) begin
            nxt.busy  = 1'b1;
            nxt.phase = 1'b0;
            nxt.pos   = '0;
        end else if (seq.busy && tick) begin
            if (!seq.phase) begin
                nxt.phase = 1'b1;
            end else begin
                nxt.phase = 1'b0;
                if (seq.pos == last_pos) begin
                    nxt.busy = 1'b0;
                    nxt.pos  = '0;
                    end_now  = 1'b1;
                end else begin
                    nxt.pos = seq.pos + tsb_pos_t'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq  <= '0;
            done <= 1'b0;
        end else begin
            seq  <= nxt;
            done <= end_now;
        end
    end

endmodule

// File: rtl/tsb_bit_mapper.sv
module tsb_bit_mapper
    import tsb_pkg::*;
#(
    parameter int unsigned MIN_CNT = 3
) (
    input  tsb_cfg_t             cfg,
    input  tsb_seq_t             seq,
    output tsb_pos_t             last_pos,
    output logic                 sdo,
    output logic                 sck,
    output logic [TSB_CS_W-1:0]  cs_out
);

    tsb_pos_t              n_data;
    tsb_pos_t              split;
    tsb_pos_t              q;
    tsb_pos_t              j;
    logic [TSB_CNT_W-1:0]  idx;
    logic                  is_head;
    logic                  is_mid;
    logic                  second;
    logic                  bit_val;

    always_comb begin
        n_data   = tsb_data_len(cfg.count, MIN_CNT);
        split    = (tsb_pos_t'(cfg.mid) > n_data) ? n_data : tsb_pos_t'(cfg.mid);
        last_pos = n_data + tsb_pos_t'(cfg.head_en) + tsb_pos_t'(cfg.mid_en)
                   - tsb_pos_t'(1);
        is_head  = cfg.head_en && (seq.pos == '0);
        q        = seq.pos - tsb_pos_t'(cfg.head_en);
        is_mid   = cfg.mid_en && (q == split);
        j        = q - tsb_pos_t'(cfg.mid_en && (q > split));
        idx      = TSB_CNT_W'(n_data - tsb_pos_t'(1) - j);
        second   = !is_head && (q >= split);
        if (is_head || is_mid)
            bit_val = 1'b0;
        else
            bit_val = tsb_pick(cfg.bypass, cfg.mask[idx], cfg.prim[idx], cfg.alt[idx]);
        sdo    = seq.busy && bit_val;
        sck    = seq.busy && seq.phase;
        cs_out = !seq.busy ? '0 : (second ? cfg.cs_b : cfg.cs_a);
    end

endmodule

// File: rtl/tsb_serializer.sv
module tsb_serializer
    import tsb_pkg::*;
#(
    parameter int unsigned MIN_CNT = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bit_tick,
    input  logic                   start,
    input  logic [TSB_CNT_W-1:0]   cfg_count,
    input  logic [TSB_CNT_W-1:0]   mid_pos,
    input  logic                   ins_head,
    input  logic                   ins_mid,
    input  logic                   bypass,
    input  logic [TSB_DATA_W-1:0]  prim_word,
    input  logic [TSB_DATA_W-1:0]  alt_word,
    input  logic [TSB_DATA_W-1:0]  sel_mask,
    input  logic [TSB_CS_W-1:0]    cs_first,
    input  logic [TSB_CS_W-1:0]    cs_second,
    output logic                   sdo,
    output logic                   sck,
    output logic [TSB_CS_W-1:0]    cs_out,
    output logic                   busy,
    output logic                   done
);

    tsb_cfg_t cfg_in;
    tsb_cfg_t cfg_q;
    tsb_seq_t seq;
    tsb_pos_t last_pos;
    logic     accept;

    assign accept = start && !seq.busy;
    assign busy   = seq.busy;

    always_comb begin
        cfg_in.count   = cfg_count;
        cfg_in.mid     = mid_pos;
        cfg_in.head_en = ins_head;
        cfg_in.mid_en  = ins_mid;
        cfg_in.bypass  = bypass;
        cfg_in.prim    = prim_word;
        cfg_in.alt     = alt_word;
        cfg_in.mask    = sel_mask;
        cfg_in.cs_a    = cs_first;
        cfg_in.cs_b    = cs_second;
    end

    tsb_cfg_latch u_cfg (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    tsb_frame_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .tick     (bit_tick),
        .last_pos (last_pos),
        .seq      (seq),
        .done     (done)
    );

    tsb_bit_mapper #(.MIN_CNT(MIN_CNT)) u_map (
        .cfg      (cfg_q),
        .seq      (seq),
        .last_pos (last_pos),
        .sdo      (sdo),
        .sck      (sck),
        .cs_out   (cs_out)
    );

endmodule

// File: rtl/tsb_serializer_chk.sv
module tsb_serializer_chk #(
    parameter int CS_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            bit_tick,
    input logic            sdo,
    input logic            sck,
    input logic [CS_W-1:0] cs_out,
    input logic            busy,
    input logic            done
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!sdo && !sck && cs_out == '0));

    assert_hold_no_tick_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && !bit_tick) |=> (busy && $stable(sck) && $stable(sdo) && $stable(cs_out)));

    assert_sck_rise_on_tick_R9: assert property (@(posedge clk) disable iff (rst)
        ($rose(sck) && $past(busy)) |-> $past(bit_tick));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_ends_frame_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy) && $past(sck)));

    assert_cs_onehot_safe_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (cs_out == '0));

endmodule

bind tsb_serializer tsb_serializer_chk #(.CS_W(tsb_pkg::TSB_CS_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bit_tick (bit_tick),
    .sdo      (sdo),
    .sck      (sck),
    .cs_out   (cs_out),
    .busy     (busy),
    .done     (done)
);

// File: tb/tsb_serializer_tb_top.sv
`timescale 1ns/1ps
module tsb_serializer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_tick = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  cfg_count = '0;
    logic [4:0]  mid_pos = '0;
    logic        ins_head = 1'b0;
    logic        ins_mid = 1'b0;
    logic        bypass = 1'b0;
    logic [31:0] prim_word = '0;
    logic [31:0] alt_word = '0;
    logic [31:0] sel_mask = '0;
    logic [7:0]  cs_first = '0;
    logic [7:0]  cs_second = '0;
    logic        sdo, sck, busy, done;
    logic [7:0]  cs_out;

    int n_cmp = 0;
    int n_bad = 0;
    int tick_div = 1;
    bit finished = 0;

    always #10 clk = ~clk;

    tsb_serializer dut_i (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .start(start),
        .cfg_count(cfg_count), .mid_pos(mid_pos), .ins_head(ins_head),
        .ins_mid(ins_mid), .bypass(bypass), .prim_word(prim_word),
        .alt_word(alt_word), .sel_mask(sel_mask), .cs_first(cs_first),
        .cs_second(cs_second), .sdo(sdo), .sck(sck), .cs_out(cs_out),
        .busy(busy), .done(done)
    );

    // behavioural reference model
    bit       q_bits[$];
    bit       q_sec[$];
    bit       m_busy, m_phase, m_done;
    int       m_pos;
    bit [7:0] m_cs1, m_cs2;

    task automatic build_frame();
        int n, m, idx;
        bit b;
        q_bits.delete();
        q_sec.delete();
        n = ((cfg_count < 3) ? 3 : int'(cfg_count)) + 1;
        m = (int'(mid_pos) > n) ? n : int'(mid_pos);
        if (ins_head) begin q_bits.push_back(1'b0); q_sec.push_back(1'b0); end
        for (int k = 0; k < n; k++) begin
            if (ins_mid && k == m) begin q_bits.push_back(1'b0); q_sec.push_back(1'b1); end
            idx = n - 1 - k;
            if (bypass) b = prim_word[idx];
            else b = sel_mask[idx] ? alt_word[idx] : prim_word[idx];
            q_bits.push_back(b);
            q_sec.push_back(k >= m);
        end
        if (ins_mid && m == n) begin q_bits.push_back(1'b0); q_sec.push_back(1'b1); end
        m_cs1 = cs_first;
        m_cs2 = cs_second;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_phase = 0; m_done = 0; m_pos = 0;
        end else begin
            m_done = 0;
            if (start && !m_busy) begin
                build_frame();
                m_busy = 1; m_phase = 0; m_pos = 0;
            end else if (m_busy && bit_tick) begin
                if (!m_phase) m_phase = 1;
                else begin
                    m_phase = 0;
                    if (m_pos == q_bits.size() - 1) begin
                        m_busy = 0; m_done = 1; m_pos = 0;
                    end else m_pos++;
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R3/R4/R5/R6/R7", "sdo", sdo, m_busy ? q_bits[m_pos] : 1'b0);
            chk("R9", "sck", sck, m_busy && m_phase);
            chk("R8", "cs_out", cs_out, m_busy ? (q_sec[m_pos] ? m_cs2 : m_cs1) : 8'h00);
            chk("R10/R11", "busy", busy, m_busy);
            chk("R10", "done", done, m_done);
        end
    end

    // tick generator
    initial begin
        int c = 0;
        forever begin
            @(negedge clk);
            c++;
            bit_tick = (tick_div <= 1) ? 1'b1 : (c % tick_div == 0);
        end
    end

    // one frame; disturb exercises R11 and R12
    task automatic run_frame(input int cnt, input int mid, input bit hd, input bit md,
                             input bit byp, input bit [31:0] p, input bit [31:0] a,
                             input bit [31:0] msk, input bit [7:0] c1, input bit [7:0] c2,
                             input int div, input bit disturb);
        int rises = 0;
        int exp_len;
        bit prev = 0;
        int guard = 0;
        @(negedge clk);
        tick_div = div;
        cfg_count = 5'(cnt); mid_pos = 5'(mid); ins_head = hd; ins_mid = md;
        bypass = byp; prim_word = p; alt_word = a; sel_mask = msk;
        cs_first = c1; cs_second = c2;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        exp_len = ((cnt < 3) ? 3 : cnt) + 1 + int'(hd) + int'(md);
        while (!done && guard < 5000) begin
            if (sck && !prev) rises++;
            prev = sck;
            guard++;
            if (disturb && guard == 7) begin
                prim_word = ~p; alt_word = ~a; sel_mask = ~msk;
                cs_first = ~c1; cs_second = ~c2; bypass = ~byp;
                cfg_count = 5'd31; ins_head = ~hd; ins_mid = ~md;
                start = 1'b1;
            end else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        chk("R2", "sck pulse count", rises, exp_len);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", "idle outputs", {sdo, sck, busy, done, cs_out}, 0);
        // R3 R4 R8: plain frame, mixed mask, every-cycle tick
        run_frame(7, 4, 0, 0, 0, 32'hA5C3_0F96, 32'h5A3C_F069, 32'h0000_00F0, 8'h01, 8'h82, 1, 0);
        // R2 R6: count below 3 clamps, head zero
        run_frame(1, 2, 1, 0, 0, 32'hFFFF_FFFF, 32'h0, 32'h0000_0005, 8'h10, 8'h20, 1, 0);
        // R7 R2: full length, both zeros, slow tick
        run_frame(31, 16, 1, 1, 0, 32'hDEAD_BEEF, 32'h1234_5678, 32'hF0F0_0F0F, 8'h0F, 8'hF0, 3, 0);
        // R5: bypass ignores mask
        run_frame(15, 8, 0, 1, 1, 32'h0000_C3A5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'h44, 8'h11, 2, 0);
        // R7 R8: split at zero with head zero
        run_frame(5, 0, 1, 1, 0, 32'h0000_002A, 32'h0000_0015, 32'h0000_0030, 8'h03, 8'hC0, 1, 0);
        // R7 R8: split beyond data clamps to end
        run_frame(3, 20, 0, 1, 0, 32'h0000_000B, 32'h0000_0004, 32'h0000_0006, 8'h81, 8'h18, 1, 0);
        // R11 R12: restart and input changes during frame
        run_frame(9, 5, 0, 1, 0, 32'h0000_0333, 32'h0000_0155, 32'h0000_00AA, 8'h06, 8'h60, 4, 1);
        // R4: alternate word fully selected
        run_frame(31, 31, 0, 0, 0, 32'h0, 32'h8001_7FFE, 32'hFFFF_FFFF, 8'hFF, 8'h00, 1, 0);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule